// File: doc/BRIEF.md
# Software-Priority Interrupt Arbiter

This block decides which interrupt the processor takes next. Each maskable vector holds a two-bit software priority code. Software writes this code through a small write port. A request pulse on a vector's line sets a pending flag. The flag stays set until that vector is taken. A pending vector is eligible only when its level is strictly above the level held in the processor's status field. Among the eligible vectors the highest level wins. When levels are equal, the lower vector index wins. Two non-maskable inputs, a top-level hardware request and a software trap, skip all of this gating. Both rank above every maskable vector.

When an interrupt is taken, the block gives the vector and its level for one cycle. In the same cycle it saves the current status level in a per-depth stack and loads the new level. A return strobe restores the saved level. In nested mode a higher-level request can preempt a running handler. In concurrent mode no maskable vector is taken while any handler is active.

Top module: `icSoftPrio`

## Requirements
- R1: After reset, no request is pending and every priority field holds code 11 (level 3). The status level is 0 (main program), the nesting depth is 0, and no take is signalled.
- R2: Priority codes decode as follows: 01 is level 1, 00 is level 2, 11 is level 3. A write of code 10 is discarded and the field keeps its previous code.
- R3: A pending maskable vector is taken only if its level is strictly greater than the current status level.
- R4: Among eligible maskable vectors, the one with the highest level is taken. At equal level, the lowest vector index is taken.
- R5: A pending top-level request is taken first, with takeVec 1. A pending trap is taken next, with takeVec 0. Both load level 3 and both ignore the status level and the servicing mode.
- R6: In a take cycle, the taken source's pending flag is cleared. At the next clock edge the status level becomes the taken level and the depth rises by one.
- R7: In nested mode (nestMode=1), the maskable gating of R3 applies at any depth. In concurrent mode (nestMode=0), no maskable vector is taken while the depth is nonzero.
- R8: A return strobe at nonzero depth restores the status level saved at that depth and lowers the depth by one. At depth 0 it changes nothing. No take is signalled in a return cycle; the pending source waits.
- R9: At the full depth (DEPTH), nothing is taken, non-maskable requests included.
- R10: A request pulse that arrives in the take cycle of the same source leaves that source pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqPulse | input | NUM_VEC | One-cycle request pulse per maskable vector |
| trapPulse | input | 1 | Software trap request pulse |
| topPulse | input | 1 | Top-level hardware request pulse |
| prioWrEn | input | 1 | Priority field write enable |
| prioWrIdx | input | IDXW | Vector whose field is written |
| prioWrCode | input | 2 | Code to write (10 is rejected) |
| nestMode | input | 1 | 1 = nested servicing, 0 = concurrent |
| retStrobe | input | 1 | Handler return |
| takeValid | output | 1 | An interrupt is taken this cycle |
| takeNmi | output | 1 | The taken source is non-maskable |
| takeVec | output | IDXW | Taken vector index (1 = top-level, 0 = trap when takeNmi) |
| takeLevel | output | 2 | Level loaded into the status field |
| curLevel | output | 2 | Current status level |
| nestDepth | output | DW | Current nesting depth |

## Verification
Several of the block's functions can fall in the same cycle. A return can coincide with a pending source that would otherwise be taken. A new pulse can arrive on the very vector that is being taken. A priority write can hit a vector in the cycle it is taken. Directed sequences force each of these collisions on purpose. Random traffic with frequent returns, writes and pulses then makes them recur many times. A reference model in the bench, written from the requirements, predicts the take, the vector, the level and the depth in every cycle. It treats a collision as follows: the return wins, the re-pulse re-pends the vector, and the write takes effect only after the take.

// File: rtl/icSoftPrioPkg.sv
package icSoftPrioPkg;

  typedef logic [1:0] level_t;

  localparam logic [1:0] CODE_FORBIDDEN = 2'b10;
  localparam logic [1:0] CODE_RESET     = 2'b11;
  localparam level_t     LVL_MAIN       = 2'd0;
  localparam level_t     LVL_TOP        = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic   take;    // a source is taken this cycle
    logic   pop;     // return at nonzero depth
    logic   nmi;     // taken source is non-maskable
    logic   nmiTop;  // non-maskable source is the top-level one
    level_t level;   // level to load into the status field
  } ctlStrobe_t;

  function automatic level_t codeToLevel(input logic [1:0] code);
    case (code)
      2'b01:   return 2'd1;
      2'b00:   return 2'd2;
      2'b11:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/icSoftPrioDatapath.sv
module icSoftPrioDatapath
  import icSoftPrioPkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int DEPTH   = 4,
  localparam int IDXW   = (NUM_VEC > 2) ? $clog2(NUM_VEC) : 1,
  localparam int DW     = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_VEC-1:0]   reqPulse,
  input  logic                 trapPulse,
  input  logic                 topPulse,
  input  logic                 wrEn,
  input  logic [IDXW-1:0]      wrIdx,
  input  logic [1:0]           wrCode,
  input  ctlStrobe_t           stb,
  input  logic [IDXW-1:0]      selIdx,
  output level_t [NUM_VEC-1:0] vecLevel,
  output logic [NUM_VEC-1:0]   vecPend,
  output logic                 trapPend,
  output logic                 topPend,
  output level_t               curLevel,
  output logic [DW-1:0]        depth
);

  // Per-vector priority code and pending flag
  for (genvar g = 0; g < NUM_VEC; g++) begin : gVec
    logic [1:0] codeQ;
    logic       clrHit;

    assign clrHit      = stb.take & ~stb.nmi & (selIdx == IDXW'(g));
    assign vecLevel[g] = codeToLevel(codeQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        codeQ      <= CODE_RESET;
        vecPend[g] <= 1'b0;
      end else begin
        if (wrEn && (wrIdx == IDXW'(g)) && (wrCode != CODE_FORBIDDEN))
          codeQ <= wrCode;
        vecPend[g] <= (vecPend[g] & ~clrHit) | reqPulse[g];
      end
    end
  end

  // Non-maskable pending flags
  logic clrTop, clrTrap;
  assign clrTop  = stb.take & stb.nmi & stb.nmiTop;
  assign clrTrap = stb.take & stb.nmi & ~stb.nmiTop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topPend  <= 1'b0;
      trapPend <= 1'b0;
    end else begin
      topPend  <= (topPend & ~clrTop) | topPulse;
      trapPend <= (trapPend & ~clrTrap) | trapPulse;
    end
  end

  // Saved-level stack, one entry per nesting depth
  level_t stackQ [DEPTH];
  level_t stackRd;

  for (genvar k = 0; k < DEPTH; k++) begin : gStack
    always_ff @(posedge clk) begin
      if (!rstN)
        stackQ[k] <= LVL_MAIN;
      else if (stb.take && (depth == DW'(k)))
        stackQ[k] <= curLevel;
    end
  end

  always_comb begin
    stackRd = LVL_MAIN;
    for (int k = 0; k < DEPTH; k++)
      if (depth == DW'(k + 1)) stackRd = stackQ[k];
  end

  // Status level and depth
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLevel <= LVL_MAIN;
      depth    <= '0;
    end else if (stb.take) begin
      curLevel <= stb.level;
      depth    <= depth + DW'(1);
    end else if (stb.pop) begin
      curLevel <= stackRd;
      depth    <= depth - DW'(1);
    end
  end

endmodule

// File: rtl/icSoftPrioControl.sv
module icSoftPrioControl
  import icSoftPrioPkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int DEPTH   = 4,
  localparam int IDXW   = (NUM_VEC > 2) ? $clog2(NUM_VEC) : 1,
  localparam int DW     = $clog2(DEPTH + 1)
) (
  input  level_t [NUM_VEC-1:0] vecLevel,
  input  logic [NUM_VEC-1:0]   vecPend,
  input  logic                 trapPend,
  input  logic                 topPend,
  input  level_t               curLevel,
  input  logic [DW-1:0]        depth,
  input  logic                 nestMode,
  input  logic                 retStrobe,
  output ctlStrobe_t           stb,
  output logic [IDXW-1:0]      selIdx
);

  logic            bestHit;
  level_t          bestLvl;
  logic [IDXW-1:0] bestIdx;

  // Highest eligible level; scanning downward with >= keeps the lowest index on a tie
  always_comb begin
    bestHit = 1'b0;
    bestLvl = LVL_MAIN;
    bestIdx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (vecPend[i] && (vecLevel[i] > curLevel) && (vecLevel[i] >= bestLvl)) begin
        bestHit = 1'b1;
        bestLvl = vecLevel[i];
        bestIdx = IDXW'(i);
      end
    end
  end

  logic stackFull, maskOpen, blocked;
  assign stackFull = (depth == DW'(DEPTH));
  assign maskOpen  = nestMode | (depth == '0);
  assign blocked   = retStrobe | stackFull;

  always_comb begin
    stb        = '0;
    selIdx     = '0;
    stb.pop    = retStrobe & (depth != '0);
    if (!blocked) begin
      if (topPend) begin
        stb.take   = 1'b1;
        stb.nmi    = 1'b1;
        stb.nmiTop = 1'b1;
        stb.level  = LVL_TOP;
        selIdx     = IDXW'(1);
      end else if (trapPend) begin
        stb.take   = 1'b1;
        stb.nmi    = 1'b1;
        stb.level  = LVL_TOP;
      end else if (maskOpen && bestHit) begin
        stb.take   = 1'b1;
        stb.level  = bestLvl;
        selIdx     = bestIdx;
      end
    end
  end

endmodule

// File: rtl/icSoftPrio.sv
module icSoftPrio
  import icSoftPrioPkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int DEPTH   = 4,
  localparam int IDXW   = (NUM_VEC > 2) ? $clog2(NUM_VEC) : 1,
  localparam int DW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] irqPulse,
  input  logic               trapPulse,
  input  logic               topPulse,
  input  logic               prioWrEn,
  input  logic [IDXW-1:0]    prioWrIdx,
  input  logic [1:0]         prioWrCode,
  input  logic               nestMode,
  input  logic               retStrobe,
  output logic               takeValid,
  output logic               takeNmi,
  output logic [IDXW-1:0]    takeVec,
  output logic [1:0]         takeLevel,
  output logic [1:0]         curLevel,
  output logic [DW-1:0]      nestDepth
);

  ctlStrobe_t           stb;
  logic [IDXW-1:0]      selIdx;
  level_t [NUM_VEC-1:0] vecLevel;
  logic [NUM_VEC-1:0]   vecPend;
  logic                 trapPend, topPend;

  icSoftPrioDatapath #(.NUM_VEC(NUM_VEC), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN),
    .reqPulse(irqPulse), .trapPulse(trapPulse), .topPulse(topPulse),
    .wrEn(prioWrEn), .wrIdx(prioWrIdx), .wrCode(prioWrCode),
    .stb(stb), .selIdx(selIdx),
    .vecLevel(vecLevel), .vecPend(vecPend),
    .trapPend(trapPend), .topPend(topPend),
    .curLevel(curLevel), .depth(nestDepth)
  );

  icSoftPrioControl #(.NUM_VEC(NUM_VEC), .DEPTH(DEPTH)) ctl_i (
    .vecLevel(vecLevel), .vecPend(vecPend),
    .trapPend(trapPend), .topPend(topPend),
    .curLevel(curLevel), .depth(nestDepth),
    .nestMode(nestMode), .retStrobe(retStrobe),
    .stb(stb), .selIdx(selIdx)
  );

  assign takeValid = stb.take;
  assign takeNmi   = stb.nmi;
  assign takeVec   = selIdx;
  assign takeLevel = stb.level;

endmodule

// File: rtl/icSoftPrioChecker.sv
module icSoftPrioChecker #(
  parameter int NUM_VEC = 8,
  parameter int DEPTH   = 4,
  localparam int DW     = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          nestMode,
  input logic          retStrobe,
  input logic          takeValid,
  input logic          takeNmi,
  input logic [1:0]    takeLevel,
  input logic [1:0]    curLevel,
  input logic [DW-1:0] nestDepth
);

  a_r3_level_above: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && !takeNmi) |-> (takeLevel > curLevel));

  a_r5_nmi_level: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && takeNmi) |-> (takeLevel == 2'd3));

  a_r6_push: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |=> (curLevel == $past(takeLevel)) && (nestDepth == DW'($past(nestDepth) + DW'(1))));

  a_r7_concurrent_hold: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && !takeNmi && !nestMode) |-> (nestDepth == '0));

  a_r8_pop: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && nestDepth != '0) |=> (nestDepth == DW'($past(nestDepth) - DW'(1))));

  a_r8_idle_return: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && nestDepth == '0) |=> (nestDepth == '0) && $stable(curLevel));

  a_r8_no_take_on_return: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe |-> !takeValid);

  a_r9_full_block: assert property (@(posedge clk) disable iff (!rstN)
    (nestDepth == DW'(DEPTH)) |-> !takeValid);

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    nestDepth <= DW'(DEPTH));

endmodule

bind icSoftPrio icSoftPrioChecker #(.NUM_VEC(NUM_VEC), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .nestMode(nestMode), .retStrobe(retStrobe),
  .takeValid(takeValid), .takeNmi(takeNmi), .takeLevel(takeLevel),
  .curLevel(curLevel), .nestDepth(nestDepth)
);

// File: tb/icSoftPrio_tb_top.sv
module icSoftPrio_tb_top;
  localparam int NV  = 8;
  localparam int DEP = 4;
  localparam int IW  = 3;
  localparam int DW  = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN;
  logic [NV-1:0] irqPulse;
  logic          trapPulse, topPulse, prioWrEn, nestMode, retStrobe;
  logic [IW-1:0] prioWrIdx;
  logic [1:0]    prioWrCode;
  logic          takeValid, takeNmi;
  logic [IW-1:0] takeVec;
  logic [1:0]    takeLevel, curLevel;
  logic [DW-1:0] nestDepth;

  icSoftPrio #(.NUM_VEC(NV), .DEPTH(DEP)) dut_i (
    .clk(clk), .rstN(rstN), .irqPulse(irqPulse), .trapPulse(trapPulse),
    .topPulse(topPulse), .prioWrEn(prioWrEn), .prioWrIdx(prioWrIdx),
    .prioWrCode(prioWrCode), .nestMode(nestMode), .retStrobe(retStrobe),
    .takeValid(takeValid), .takeNmi(takeNmi), .takeVec(takeVec),
    .takeLevel(takeLevel), .curLevel(curLevel), .nestDepth(nestDepth)
  );

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [1:0]    mCode [NV];
  logic [NV-1:0] mPend;
  logic          mTrap, mTop;
  logic [1:0]    mLvl;
  logic [1:0]    mStack [DEP];
  int            mDepth;

  function automatic logic [1:0] lvlOf(input logic [1:0] c);
    case (c)
      2'b01:   return 2'd1;
      2'b00:   return 2'd2;
      2'b11:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NV; i++) mCode[i] = 2'b11;
    for (int k = 0; k < DEP; k++) mStack[k] = 2'd0;
    mPend = '0; mTrap = 1'b0; mTop = 1'b0; mLvl = 2'd0; mDepth = 0;
  endtask

  task automatic step(input string tag, input logic ret, input logic [NV-1:0] req,
                      input logic trap, input logic top, input logic wr, input int idx,
                      input logic [1:0] code, input logic mode);
    logic eV, eNmi, eTop;
    int   eIdx;
    logic [1:0] eLvl;
    @(negedge clk);
    retStrobe = ret; irqPulse = req; trapPulse = trap; topPulse = top;
    prioWrEn = wr; prioWrIdx = IW'(idx); prioWrCode = code; nestMode = mode;
    #1;
    eV = 1'b0; eNmi = 1'b0; eTop = 1'b0; eIdx = 0; eLvl = 2'd0;
    if (!ret && mDepth < DEP) begin
      if (mTop) begin
        eV = 1'b1; eNmi = 1'b1; eTop = 1'b1; eIdx = 1; eLvl = 2'd3;
      end else if (mTrap) begin
        eV = 1'b1; eNmi = 1'b1; eIdx = 0; eLvl = 2'd3;
      end else if (mode || mDepth == 0) begin
        for (int i = 0; i < NV; i++)
          if (mPend[i] && lvlOf(mCode[i]) > mLvl && lvlOf(mCode[i]) > eLvl) begin
            eV = 1'b1; eIdx = i; eLvl = lvlOf(mCode[i]);
          end
      end
    end
    chk(tag, "R3/R7/R9 takeValid", takeValid, eV);
    if (eV) begin
      chk(tag, "R5 takeNmi", takeNmi, eNmi);
      chk(tag, "R4/R5 takeVec", takeVec, eIdx);
      chk(tag, "R2/R5/R6 takeLevel", takeLevel, eLvl);
    end
    chk(tag, "R6/R8 curLevel", curLevel, mLvl);
    chk(tag, "R6/R8/R9 nestDepth", nestDepth, mDepth);
    @(posedge clk);
    if (eV) begin
      if (eNmi) begin
        if (eTop) mTop = 1'b0; else mTrap = 1'b0;
      end else mPend[eIdx] = 1'b0;
      mStack[mDepth] = mLvl;
      mDepth++;
      mLvl = eLvl;
    end else if (ret && mDepth > 0) begin
      mDepth--;
      mLvl = mStack[mDepth];
    end
    mPend = mPend | req;
    mTrap = mTrap | trap;
    mTop  = mTop | top;
    if (wr && code != 2'b10) mCode[idx] = code;
  endtask

  task automatic idle(input string tag, input logic mode);
    step(tag, 1'b0, '0, 1'b0, 1'b0, 1'b0, 0, 2'b00, mode);
  endtask

  task automatic ret(input string tag, input logic mode);
    step(tag, 1'b1, '0, 1'b0, 1'b0, 1'b0, 0, 2'b00, mode);
  endtask

  task automatic pulse(input string tag, input logic [NV-1:0] req, input logic mode);
    step(tag, 1'b0, req, 1'b0, 1'b0, 1'b0, 0, 2'b00, mode);
  endtask

  task automatic wrPrio(input string tag, input int idx, input logic [1:0] code);
    step(tag, 1'b0, '0, 1'b0, 1'b0, 1'b1, idx, code, 1'b1);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 10; i++) ret(tag, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; irqPulse = '0; trapPulse = 1'b0; topPulse = 1'b0;
    prioWrEn = 1'b0; prioWrIdx = '0; prioWrCode = 2'b00; nestMode = 1'b1; retStrobe = 1'b0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state seen at the ports
    chk("R1 reset", "takeValid", takeValid, 0);
    chk("R1 reset", "curLevel", curLevel, 0);
    chk("R1 reset", "nestDepth", nestDepth, 0);

    // R1: default field is level 3
    pulse("R1 default level", 8'h20, 1'b1);
    idle("R1 default level", 1'b1);
    ret("R1 default level", 1'b1);

    // R2: encodings, forbidden code discarded
    wrPrio("R2 encode", 0, 2'b01);
    wrPrio("R2 forbidden", 0, 2'b10);
    wrPrio("R2 encode", 1, 2'b00);
    pulse("R2 level one", 8'h01, 1'b1);
    idle("R2 level one", 1'b1);
    ret("R2 level one", 1'b1);

    // R4: tie resolved by lowest index; R3: equal level blocked
    pulse("R4 tie", 8'h44, 1'b1);
    idle("R4 tie", 1'b1);
    idle("R3 equal level blocked", 1'b1);
    ret("R3 equal level blocked", 1'b1);
    idle("R4 tie second", 1'b1);
    ret("R4 tie second", 1'b1);

    // R4: higher level first, R3 lower waits
    pulse("R4 level order", 8'h03, 1'b1);
    idle("R4 level order", 1'b1);
    idle("R3 lower waits", 1'b1);
    ret("R3 lower waits", 1'b1);
    idle("R3 lower taken", 1'b1);
    ret("R3 lower taken", 1'b1);

    // R7: nested preemption
    pulse("R7 nested", 8'h01, 1'b1);
    idle("R7 nested", 1'b1);
    pulse("R7 nested preempt", 8'h02, 1'b1);
    idle("R7 nested preempt", 1'b1);
    ret("R7 nested", 1'b1);
    ret("R7 nested", 1'b1);

    // R7: concurrent holds until return
    pulse("R7 concurrent", 8'h01, 1'b0);
    idle("R7 concurrent", 1'b0);
    pulse("R7 concurrent hold", 8'h02, 1'b0);
    idle("R7 concurrent hold", 1'b0);
    idle("R7 concurrent hold", 1'b0);
    ret("R7 concurrent release", 1'b0);
    idle("R7 concurrent release", 1'b0);
    ret("R7 concurrent release", 1'b0);

    // R5: non-maskable at level 3, ahead of maskable, concurrent mode
    pulse("R5 level three", 8'h80, 1'b0);
    idle("R5 level three", 1'b0);
    step("R5 nmi", 1'b0, 8'h02, 1'b1, 1'b1, 1'b0, 0, 2'b00, 1'b0);
    idle("R5 top first", 1'b0);
    idle("R5 trap next", 1'b0);
    drain("R5 drain");
    idle("R5 drain", 1'b1);
    drain("R5 drain");

    // R9: stack full blocks even top-level
    for (int i = 0; i < 5; i++)
      step("R9 fill", 1'b0, '0, 1'b0, 1'b1, 1'b0, 0, 2'b00, 1'b1);
    idle("R9 full", 1'b1);
    idle("R9 full", 1'b1);
    drain("R9 drain");

    // R8: return at depth zero changes nothing
    ret("R8 idle return", 1'b1);
    ret("R8 idle return", 1'b1);

    // R10: re-pulse during take cycle re-pends
    pulse("R10 repend", 8'h08, 1'b1);
    pulse("R10 repend", 8'h08, 1'b1);
    ret("R10 repend", 1'b1);
    idle("R10 repend", 1'b1);
    ret("R10 repend", 1'b1);

    // R8: return wins over a pending take; write in take cycle applies after
    pulse("R8 ret vs take", 8'h10, 1'b1);
    ret("R8 ret vs take", 1'b1);
    step("R8 ret vs take", 1'b0, '0, 1'b0, 1'b0, 1'b1, 4, 2'b01, 1'b1);
    ret("R8 ret vs take", 1'b1);

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [NV-1:0] rq;
      logic          m;
      for (int b = 0; b < NV; b++) rq[b] = ($urandom % 12) == 0;
      m = (n / 300) % 2 == 0;
      step("random", ($urandom % 5) == 0, rq, ($urandom % 40) == 0, ($urandom % 60) == 0,
           ($urandom % 5) == 0, int'($urandom % NV), 2'($urandom % 4), m);
    end
    drain("final drain");

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule